// File: doc/BRIEF.md
# Programmable UART Baud Rate Generator

This block turns a fast input clock into the 16x sampling clock that a UART transmitter and receiver use. The division ratio is a 16-bit value. A host loads it one byte at a time through two write strobes that share one data byte. A write to either byte restarts the internal down-counter at once. A new rate therefore takes effect on the next cycle and does not wait for a long count under the old value to run out.

Small divisors produce their own waveforms. A value of 0 divides the clock by three. A value of 1 passes the inverted input clock straight through. A value of 2 gives a square wave at half the input frequency. Any larger value N gives a period of N input cycles: the output is low for the first two cycles and high for the rest. Next to the waveform, the block gives a single-cycle enable that is high in the cycle where the output goes high. Synchronous logic downstream can use this enable in place of the generated clock.

Top module: `baud_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the divisor becomes 0, `baud_out` and `baud_tick` are low after that edge, and the first period after reset starts at its first low cycle.
- R2: A `wr_lo` pulse loads `wr_data` into divisor bits 7:0, and a `wr_hi` pulse loads it into bits 15:8. The other byte keeps its value. When both strobes are high together, both bytes take the same data.
- R3: The cycle after any divisor write is the first cycle of a new period, and the count begins again from the full new period, whatever phase the old count was in.
- R4: With divisor 0, the output repeats every 3 input cycles: low, low, high.
- R5: With divisor 1, `baud_out` is the logical inverse of `clk`, and `baud_tick` stays high.
- R6: With divisor 2, the output repeats every 2 cycles: one cycle low, then one cycle high (50% duty).
- R7: With divisor N of 3 or more, the output repeats every N cycles: low for 2 cycles, then high for N-2 cycles.
- R8: Outside divisor 1, `baud_tick` is high for exactly the one cycle in which `baud_out` first goes high in each period, and low otherwise.
- R9: With no write strobe, the divisor holds its value and the waveform repeats without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| wr_lo | input | 1 | Write strobe for divisor low byte |
| wr_hi | input | 1 | Write strobe for divisor high byte |
| wr_data | input | 8 | Byte written to the selected divisor half |
| baud_out | output | 1 | 16x baud waveform |
| baud_tick | output | 1 | One-cycle enable on each rising edge of `baud_out` |

## Verification
The assertions assume that the strobes and the data byte are synchronous to `clk` and settle well before the rising edge. They also assume that reset is held for at least one edge at start-up, because the two-cycle low-phase check looks back past the reset. The stimulus drives every input a fixed delay after the rising edge and asserts reset from time zero. It samples outputs in both clock phases, so the inverted-clock output of divisor 1 is seen at both of its levels. Writes arrive in the middle of a period, on the same byte twice in a row, and on both bytes at once. This tests the restart of the count and the byte routing against the phases where they matter.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic [1:0] {
    MODE_DIV3 = 2'd0,   // divisor 0: period of three
    MODE_INV  = 2'd1,   // divisor 1: inverted input clock
    MODE_HALF = 2'd2,   // divisor 2: 50% square wave
    MODE_GEN  = 2'd3    // divisor >= 3: two low, rest high
  } brg_mode_e;

  function automatic brg_mode_e brg_classify(input logic is_zero,
                                             input logic is_one,
                                             input logic is_two);
    if (is_zero)     return MODE_DIV3;
    else if (is_one) return MODE_INV;
    else if (is_two) return MODE_HALF;
    else             return MODE_GEN;
  endfunction

endpackage

// File: rtl/brg_divisor_regs.sv
module brg_divisor_regs #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int DIV_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_d,
  output logic              load,
  output logic              is_one_q
);

  assign load = |wr_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign div_d[g*BYTE_W +: BYTE_W] =
      wr_lane[g] ? wr_data : div_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      is_one_q <= 1'b0;
    end else begin
      div_q    <= div_d;
      is_one_q <= (div_d == DIV_W'(1));
    end
  end

  // R9: no strobe, no change of the stored divisor
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(div_q));

  // R2: the low lane takes the data byte
  p_lo_lane_r2: assert property (@(posedge clk) disable iff (rst)
    wr_lane[0] |=> div_q[BYTE_W-1:0] == $past(wr_data));

  // R1: reset clears the divisor
  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (div_q == '0) && !is_one_q);

endmodule

// File: rtl/brg_counter.sv
module brg_counter
  import brg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_d,
  input  logic [DIV_W-1:0] div_q,
  input  logic             load,
  output logic             wave_q,
  output logic             tick_q
);

  localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);
  localparam logic [DIV_W-1:0] TWO   = DIV_W'(2);
  localparam logic [DIV_W-1:0] THREE = DIV_W'(3);

  brg_mode_e        mode_d;
  logic [DIV_W-1:0] period_m1;
  logic [DIV_W-1:0] hi_start;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign mode_d = brg_classify(div_d == '0, div_d == ONE, div_d == TWO);

  always_comb begin
    unique case (mode_d)
      MODE_DIV3: begin period_m1 = TWO;         hi_start = '0;           end
      MODE_INV:  begin period_m1 = '0;          hi_start = '0;           end
      MODE_HALF: begin period_m1 = ONE;         hi_start = '0;           end
      default:   begin period_m1 = div_d - ONE; hi_start = div_d - THREE; end
    endcase
  end

  assign cnt_d = (load || cnt_q == '0) ? period_m1 : cnt_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= TWO;
      wave_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= (mode_d != MODE_INV) && (cnt_d <= hi_start);
      tick_q <= (mode_d == MODE_INV) || (cnt_d == hi_start);
    end
  end

  // R1: outputs low right after reset
  p_rst_low_r1: assert property (@(posedge clk)
    rst |=> !wave_q && !tick_q);

  // R3: a write starts a period at its low phase
  p_reload_low_r3: assert property (@(posedge clk) disable iff (rst)
    (load && mode_d != MODE_INV) |=> !wave_q);

  // R8: enable only while the waveform is high
  p_tick_high_r8: assert property (@(posedge clk) disable iff (rst)
    (tick_q && div_q != ONE) |-> wave_q);

  // R8: every rise carries the enable
  p_rise_tick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wave_q) |-> tick_q);

  // R7: two low cycles precede each rise for the general shape
  p_low_two_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(wave_q) && div_q != TWO) |-> !$past(wave_q, 2));

endmodule

// File: rtl/brg_outmux.sv
module brg_outmux (
  input  logic clk,
  input  logic inv_sel,
  input  logic wave_q,
  output logic baud_out
);

  // Divide-by-one path: the inverted input clock, chosen from a registered select
  assign baud_out = inv_sel ? ~clk : wave_q;

endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int BYTE_W = 8,
  localparam int LANES = 2,
  localparam int DIV_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              baud_out,
  output logic              baud_tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic             load;
  logic             is_one_q;
  logic             wave_q;

  brg_divisor_regs #(.BYTE_W(BYTE_W), .LANES(LANES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_lane  ({wr_hi, wr_lo}),
    .wr_data  (wr_data),
    .div_q    (div_q),
    .div_d    (div_d),
    .load     (load),
    .is_one_q (is_one_q)
  );

  brg_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .div_d  (div_d),
    .div_q  (div_q),
    .load   (load),
    .wave_q (wave_q),
    .tick_q (baud_tick)
  );

  brg_outmux u_mux (
    .clk      (clk),
    .inv_sel  (is_one_q),
    .wave_q   (wave_q),
    .baud_out (baud_out)
  );

endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_out;
  logic       baud_tick;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    armed = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_div = 0;
  int m_k = 0;

  baud_gen u_dut (
    .clk       (clk),
    .rst       (rst),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .baud_out  (baud_out),
    .baud_tick (baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(int d);
    return (d == 0) ? 3 : d;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_div = 0;
      m_k   = 0;
      armed = 1;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) m_div = (m_div & 32'hFF00) | int'(wr_data);
      if (wr_hi) m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
      m_k = 0;
    end else begin
      m_k = (m_k + 1) % period_of(m_div);
    end
  end

  task automatic compare(input bit just_reset);
    int  p;
    int  lowlen;
    bit  e_out;
    bit  e_tick;
    p      = period_of(m_div);
    lowlen = (p == 2) ? 1 : 2;
    if (just_reset) begin
      e_out = 0; e_tick = 0;
    end else if (p == 1) begin
      e_out = ~clk; e_tick = 1;
    end else begin
      e_out  = (m_k >= lowlen);
      e_tick = (m_k == lowlen);
    end
    checks++;
    if (baud_out !== e_out || baud_tick !== e_tick) begin
      failures++;
      $display("FAIL %s: out=%b tick=%b expected out=%b tick=%b (div=%0d phase=%0d)",
               cur_req, baud_out, baud_tick, e_out, e_tick, m_div, m_k);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (armed) compare(rst);
    #5;
    if (armed) compare(rst);
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: cycle=%0d expected end before %0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic write(input bit lo, input bit hi, input logic [7:0] d);
    @(posedge clk);
    #4;
    wr_lo = lo; wr_hi = hi; wr_data = d;
    @(posedge clk);
    #4;
    wr_lo = 0; wr_hi = 0;
  endtask

  initial begin
    // R1: reset state, then divide-by-three default
    cur_req = "R1";
    idle(3);
    #4 rst = 0;
    cur_req = "R4";
    idle(10);
    // R7: general shape with divisor 5
    cur_req = "R7";
    write(1, 0, 8'd5);
    idle(20);
    // R5: inverted clock
    cur_req = "R5";
    write(1, 0, 8'd1);
    idle(6);
    // R6: half-rate square wave
    cur_req = "R6";
    write(1, 0, 8'd2);
    idle(8);
    // R4: divisor 0 after others
    cur_req = "R4";
    write(1, 0, 8'd0);
    idle(9);
    // R7: smallest general divisor
    cur_req = "R7";
    write(1, 0, 8'd3);
    idle(9);
    // R2: high byte gives 259
    cur_req = "R2";
    write(0, 1, 8'd1);
    idle(600);
    // R3: rewrite in the middle of a period
    cur_req = "R3";
    write(0, 1, 8'd0);
    write(1, 0, 8'd7);
    idle(4);
    write(1, 0, 8'd9);
    idle(5);
    write(1, 0, 8'd9);
    idle(20);
    // R2: both strobes together
    cur_req = "R2";
    write(1, 1, 8'd0);
    idle(9);
    // R8 / R9: steady running with enable pulses
    cur_req = "R8";
    write(1, 0, 8'd6);
    idle(30);
    cur_req = "R9";
    idle(40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule